// File: doc/BRIEF.md
# Link Heartbeat Generator and Monitor

This block keeps an Ethernet port's link alive and watches that the far end is alive. A programmable period, counted in slot times of 512 bit times, governs both directions. When the port has transmitted nothing for half of that period, the block asks the MAC for a heartbeat control frame. When no good frame has been received for the whole period, it raises a sticky timeout interrupt.

Heartbeat frames and processor-forced frames both use the MAC control frame layout, the same layout as a pause frame. The block never builds frames. It only hands the MAC a request through a valid/ready handshake that carries a 16-bit opcode. The heartbeat opcode and the forced-frame opcode come from two separate registers; 0x0012 is a sensible heartbeat opcode. The request side is a three-state machine:
- `ST_IDLE` moves to `ST_FORCE` when a forced frame is waiting, or otherwise to `ST_BEAT` when a heartbeat is waiting.
- `ST_FORCE` and `ST_BEAT` each return to `ST_IDLE` when the MAC accepts the request.

Frame serialization, CRC and the MAC itself are outside the block.

Top module: `link_heartbeat`

## Requirements
- R1: One slot time is 512 strobes of `bit_tick`. The idle counters advance only on those strobes: with `bit_tick` low, no request and no interrupt appear, however many clock cycles pass.
- R2: With `period` = P (non-zero), a heartbeat request (`frm_valid`=1, `frm_opcode`=`beat_opcode`) appears once no `tx_seen` pulse has occurred for P×256 bit times. A request appears after at most P×256 bit times plus a few clocks, and never before (P−1)×256 bit times.
- R3: Every `tx_seen` pulse, including the one for a transmitted heartbeat, restarts the transmit idle count.
- R4: `irq` goes to 1 once no `rx_good` pulse has occurred for P×512 bit times. It is set after at most P×512 bit times plus one clock, and never before (P−1)×512 bit times.
- R5: Every `rx_good` pulse restarts the receive idle count.
- R6: `period` = 0 disables both heartbeat requests and timeout detection.
- R7: `frm_valid` stays 1 and `frm_opcode` stays unchanged until `frm_ready` is seen high, even if the opcode registers change meanwhile. The clock after acceptance, `frm_valid` is 0.
- R8: A `force_req` pulse requests a frame with `force_opcode`. When a forced frame and a heartbeat are both waiting, the forced frame is issued first and the heartbeat remains pending and is issued next.
- R9: `irq` stays 1 until an `irq_clr` pulse clears it. The receive count restarts each time it fires, so the next assertion comes exactly P×512 bit times after the previous one.
- R10: After reset, `frm_valid` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-clock strobe per bit time |
| tx_seen | input | 1 | Pulse per frame transmitted by the port |
| rx_good | input | 1 | Pulse per good frame received |
| period | input | 8 | Timeout period in slot times; 0 disables |
| beat_opcode | input | 16 | Opcode for heartbeat frames |
| force_opcode | input | 16 | Opcode for processor-forced frames |
| force_req | input | 1 | Pulse: processor asks for a control frame |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| frm_valid | output | 1 | Control frame request valid |
| frm_ready | input | 1 | MAC accepts the request |
| frm_opcode | output | 16 | Opcode of the requested frame |
| irq | output | 1 | Sticky receive-timeout interrupt |

## Verification
The hardest situation to reach from the ports is a forced frame and a heartbeat pending at the same moment while the MAC holds off acceptance. Without a stall, the forced frame drains in two clocks and never overlaps the heartbeat. The stimulus therefore holds `frm_ready` low, issues `force_req`, and waits longer than half the period so that the heartbeat also becomes pending behind it. Then it accepts one frame at a time and checks the order and the opcodes. The exact re-fire interval of the interrupt is found by polling for its first rise, which fixes the otherwise unknown slot phase.

// File: rtl/lhb_pkg.sv
package lhb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FORCE = 2'd1,
        ST_BEAT  = 2'd2
    } req_state_t;

    localparam int CH_TX = 0;
    localparam int CH_RX = 1;
    localparam int N_CH  = 2;
endpackage

// File: rtl/lhb_slot_prescaler.sv
module lhb_slot_prescaler #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    output logic half_tick,
    output logic slot_tick
);
    localparam int CW   = $clog2(SLOT_BITS);
    localparam int HALF = SLOT_BITS / 2;

    logic [CW-1:0] cnt_q;
    logic          at_end;
    logic          at_half;

    assign at_end  = (cnt_q == CW'(SLOT_BITS - 1));
    assign at_half = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign half_tick = bit_tick && (at_half || at_end);
    assign slot_tick = bit_tick && at_end;
endmodule

// File: rtl/lhb_idle_timer.sv
module lhb_idle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] thr,
    output logic         fire
);
    logic [W-1:0] cnt_q;
    logic         en;
    logic         last;

    assign en   = (thr != '0);
    assign last = (cnt_q >= thr - 1'b1);
    assign fire = en && tick && !clear && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lhb_req_sequencer.sv
module lhb_req_sequencer
    import lhb_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            beat_set,
    input  logic            force_set,
    input  logic [OP_W-1:0] beat_op,
    input  logic [OP_W-1:0] force_op,
    input  logic            ready,
    output logic            valid,
    output logic [OP_W-1:0] op,
    output logic            force_waiting
);
    req_state_t      state_q, state_d;
    logic            force_pend_q, beat_pend_q;
    logic            took_force, took_beat;
    logic [OP_W-1:0] op_q;

    assign took_force = (state_q == ST_FORCE) && ready;
    assign took_beat  = (state_q == ST_BEAT)  && ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (force_pend_q)     state_d = ST_FORCE;
                else if (beat_pend_q) state_d = ST_BEAT;
            end
            ST_FORCE: if (ready) state_d = ST_IDLE;
            ST_BEAT:  if (ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_pend_q <= 1'b0;
            beat_pend_q  <= 1'b0;
        end else begin
            force_pend_q <= (force_pend_q && !took_force) || force_set;
            beat_pend_q  <= (beat_pend_q && !took_beat) || beat_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (state_d == ST_FORCE)     op_q <= force_op;
            else if (state_d == ST_BEAT) op_q <= beat_op;
        end
    end

    always_comb begin
        valid         = (state_q != ST_IDLE);
        op            = op_q;
        force_waiting = force_pend_q;
    end
endmodule

// File: rtl/link_heartbeat.sv
module link_heartbeat
    import lhb_pkg::*;
#(
    parameter int SLOT_BITS = 512,
    parameter int PER_W     = 8,
    parameter int OP_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_seen,
    input  logic             rx_good,
    input  logic [PER_W-1:0] period,
    input  logic [OP_W-1:0]  beat_opcode,
    input  logic [OP_W-1:0]  force_opcode,
    input  logic             force_req,
    input  logic             irq_clr,
    output logic             frm_valid,
    input  logic             frm_ready,
    output logic [OP_W-1:0]  frm_opcode,
    output logic             irq
);
    logic            half_tick, slot_tick;
    logic [N_CH-1:0] tick_v, clr_v, fire_v;
    logic            force_pend;
    logic            irq_q;

    lhb_slot_prescaler #(.SLOT_BITS(SLOT_BITS)) i_presc (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .half_tick(half_tick), .slot_tick(slot_tick)
    );

    // Transmit side counts half slots, receive side full slots, to the same limit.
    assign tick_v[CH_TX] = half_tick;
    assign tick_v[CH_RX] = slot_tick;
    assign clr_v[CH_TX]  = tx_seen;
    assign clr_v[CH_RX]  = rx_good;

    for (genvar g = 0; g < N_CH; g++) begin : g_idle
        lhb_idle_timer #(.W(PER_W)) i_timer (
            .clk(clk), .rst_n(rst_n), .tick(tick_v[g]), .clear(clr_v[g]),
            .thr(period), .fire(fire_v[g])
        );
    end

    lhb_req_sequencer #(.OP_W(OP_W)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .beat_set(fire_v[CH_TX]), .force_set(force_req),
        .beat_op(beat_opcode), .force_op(force_opcode),
        .ready(frm_ready), .valid(frm_valid), .op(frm_opcode),
        .force_waiting(force_pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)              irq_q <= 1'b0;
        else if (fire_v[CH_RX])  irq_q <= 1'b1;
        else if (irq_clr)        irq_q <= 1'b0;
    end

    assign irq = irq_q;
endmodule

// File: rtl/lhb_checker.sv
module lhb_checker #(
    parameter int PER_W = 8,
    parameter int OP_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PER_W-1:0] period,
    input logic [OP_W-1:0]  force_opcode,
    input logic             irq_clr,
    input logic             frm_valid,
    input logic             frm_ready,
    input logic [OP_W-1:0]  frm_opcode,
    input logic             irq,
    input logic             force_pend,
    input logic [1:0]       fire_v
);
    // R7: request held with a stable opcode until accepted
    a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_opcode));

    // R7: the clock after acceptance the request is gone
    a_r7_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_ready |=> !frm_valid);

    // R9: interrupt is sticky while no clear arrives
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);

    // R9: clear without a new timeout drops the interrupt
    a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !fire_v[1] |=> !irq);

    // R6: a zero period lets neither idle timer fire
    a_r6_zero_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> (fire_v == 2'b00));

    // R8: a waiting forced frame wins the next request slot
    a_r8_force_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_valid) && $past(force_pend) |-> frm_opcode == $past(force_opcode));
endmodule

bind link_heartbeat lhb_checker #(.PER_W(PER_W), .OP_W(OP_W)) i_lhb_checker (
    .clk(clk), .rst_n(rst_n), .period(period), .force_opcode(force_opcode),
    .irq_clr(irq_clr), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_opcode(frm_opcode), .irq(irq), .force_pend(force_pend), .fire_v(fire_v)
);

// File: tb/test_link_heartbeat.sv
module test_link_heartbeat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, tx_seen = 1'b0, rx_good = 1'b0;
    logic [7:0]  period = 8'd0;
    logic [15:0] beat_opcode = 16'h0012, force_opcode = 16'h0101;
    logic        force_req = 1'b0, irq_clr = 1'b0, frm_ready = 1'b0;
    logic        frm_valid, irq;
    logic [15:0] frm_opcode;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    link_heartbeat i_link_heartbeat (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_seen(tx_seen),
        .rx_good(rx_good), .period(period), .beat_opcode(beat_opcode),
        .force_opcode(force_opcode), .force_req(force_req), .irq_clr(irq_clr),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_opcode(frm_opcode),
        .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_tx();
        tx_seen = 1'b1; tick(1); tx_seen = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_good = 1'b1; tick(1); rx_good = 1'b0;
    endtask

    task automatic quiesce();
        period = 8'd0; frm_ready = 1'b1; tick(10);
        frm_ready = 1'b0; irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        bit_tick = 1'b1;
    endtask

    task automatic t_reset();
        check(frm_valid == 1'b0, "R10 valid", frm_valid, 0);
        check(irq == 1'b0, "R10 irq", irq, 0);
    endtask

    task automatic t_beat();
        quiesce();
        period = 8'd4; beat_opcode = 16'h0012;
        pulse_tx();
        for (int i = 0; i < 6; i++) begin
            tick(500); pulse_tx();
        end
        check(frm_valid == 1'b0, "R3 restart", frm_valid, 0);
        tick(758);
        check(frm_valid == 1'b0, "R2 not early", frm_valid, 0);
        tick(290);
        check(frm_valid == 1'b1, "R2 request", frm_valid, 1);
        check(frm_opcode == 16'h0012, "R2 opcode", frm_opcode, 16'h0012);
        beat_opcode = 16'h0BAD; tick(20);
        check(frm_valid && frm_opcode == 16'h0012, "R7 stable", frm_opcode, 16'h0012);
        frm_ready = 1'b1; tick(1); frm_ready = 1'b0;
        check(frm_valid == 1'b0, "R7 drop", frm_valid, 0);
    endtask

    task automatic t_rx_and_sticky();
        int waited;
        quiesce();
        period = 8'd4;
        pulse_rx();
        for (int i = 0; i < 3; i++) begin
            tick(1400); pulse_rx();
        end
        check(irq == 1'b0, "R5 restart", irq, 0);
        tick(1526);
        check(irq == 1'b0, "R4 not early", irq, 0);
        waited = 0;
        while (!irq && waited < 600) begin
            tick(1); waited++;
        end
        check(irq == 1'b1, "R4 timeout", irq, 1);
        tick(100);
        check(irq == 1'b1, "R9 sticky", irq, 1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        check(irq == 1'b0, "R9 clear", irq, 0);
        tick(1929);
        check(irq == 1'b0, "R9 no early refire", irq, 0);
        tick(30);
        check(irq == 1'b1, "R9 refire", irq, 1);
    endtask

    task automatic t_zero_and_strobe();
        quiesce();
        tick(3000);
        check(frm_valid == 1'b0, "R6 no beat", frm_valid, 0);
        check(irq == 1'b0, "R6 no irq", irq, 0);
        bit_tick = 1'b0; period = 8'd1;
        pulse_tx(); pulse_rx();
        tick(3000);
        check(frm_valid == 1'b0, "R1 frozen beat", frm_valid, 0);
        check(irq == 1'b0, "R1 frozen irq", irq, 0);
        bit_tick = 1'b1;
        tick(600);
        check(frm_valid == 1'b1, "R1 resumes beat", frm_valid, 1);
        check(irq == 1'b1, "R1 resumes irq", irq, 1);
    endtask

    task automatic t_force();
        quiesce();
        period = 8'd4; beat_opcode = 16'h0012; force_opcode = 16'h0101;
        pulse_tx();
        tick(4);
        force_req = 1'b1; tick(1); force_req = 1'b0;
        tick(3);
        check(frm_valid && frm_opcode == 16'h0101, "R8 forced", frm_opcode, 16'h0101);
        tick(1100);
        check(frm_valid && frm_opcode == 16'h0101, "R8 force held", frm_opcode, 16'h0101);
        frm_ready = 1'b1; tick(1); frm_ready = 1'b0;
        tick(4);
        check(frm_valid && frm_opcode == 16'h0012, "R8 beat next", frm_opcode, 16'h0012);
        frm_ready = 1'b1; tick(1); frm_ready = 1'b0;
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_beat();
        t_rx_and_sticky();
        t_zero_and_strobe();
        t_force();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule